// File: doc/BRIEF.md
# Prioritised Multi-Context Interrupt Router

This block gathers level-sensitive interrupt requests from a parameterised set of sources and routes them to a set of hart contexts. Each source has a programmable priority. Each context has its own enable mask and a priority threshold. Each context drives one interrupt output, which stays high while that context has at least one eligible source.

Software on a context services interrupts through a single claim/complete word. A read of that word returns the identifier of the best eligible pending source and takes that source out of the pending set in the same cycle. The handler later writes the identifier back to the same word. Until that write arrives, the source cannot latch a new request. All registers sit on a simple 32-bit read/write bus with a registered read path.

Top module: `irq_router`

## Requirements
- R1: Source identifier 0 does not exist. Its priority word always reads 0, writes to it are ignored, and a claim read of 0 means no eligible source is pending.
- R2: Register map (byte addresses). Priority of source n is at 4*n. The enable word w of context c is at 0x2000 + 0x80*c + 4*w, where bit b enables source 32*w+b. The threshold of context c is at 0x200000 + 0x1000*c, and its claim/complete word is at that address + 4. Priority and threshold hold PRIO_W bits and read back zero-extended. Read data appears on `rd_data` one cycle after `rd_en`.
- R3: A source is eligible for a context only if it is pending, enabled for that context, and its priority is strictly greater than the context threshold. With the maximum threshold (7), no source is eligible. A priority of 0 is never eligible.
- R4: Enable masks are independent per context. A source enabled only in context 1 raises only `irq_o[1]` and cannot be claimed from context 0.
- R5: A claim read returns the eligible source with the highest priority. On equal priority, the lower identifier wins.
- R6: A claim read clears the returned source's pending bit and marks the source in service. While the source is in service, an input held high does not make it pending again.
- R7: Successive claim reads return the remaining eligible sources in priority order, then return 0.
- R8: Writing a source identifier to a context's claim/complete word ends service for that source, after which the input may latch a new request. The write is ignored if that source is not enabled in that context, or if the identifier is 0 or not below NSRC (no truncation).
- R9: `irq_o[c]` is a registered level. It reflects eligibility one cycle after a change to pending, enable, priority or threshold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NSRC | Level interrupt request per source (bit 0 unused) |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_o | output | NCTX | Interrupt output per context |

## Verification
The bench covers the case where priority equals the threshold. A design that compares with greater-or-equal would assert the interrupt here. It also checks tied priorities, where a wrong comparison would return the higher identifier. A completion written with an identifier above the range is checked too: an address decode that truncates the identifier would wrongly free source 4 when 36 is written. Completions from a context that lacks the enable, or after the enable was cleared, must leave the source in service. A design that re-latched held-high inputs during service would return the same source on a second claim. The cycle in which the output follows a threshold write is checked, so a combinational output, or one delayed by an extra register, is reported.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC   = 32,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_irq,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic [NCTX-1:0]   irq_o
);
  localparam int IDW    = $clog2(NSRC);
  localparam int NWORDS = (NSRC + 31) / 32;
  localparam int EN_BASE = 'h2000;
  localparam int EN_STEP = 'h80;
  localparam int CX_BASE = 'h200000;
  localparam int CX_STEP = 'h1000;
  localparam logic [ADDR_W-1:0] PRIO_END = ADDR_W'(4 * NSRC);

  logic [PRIO_W-1:0] prio [NSRC];
  logic [NSRC-1:0]   en   [NCTX];
  logic [PRIO_W-1:0] thr  [NCTX];
  logic [NSRC-1:0]   pend, busy, clm, cmp;
  logic [IDW-1:0]    best_id [NCTX];
  logic [PRIO_W-1:0] best_pr [NCTX];
  logic [NCTX-1:0]   claim_hit, cmpl_hit, thr_hit;
  logic [31:0]       rd_val;

  wire              is_prio  = addr < PRIO_END;
  wire [IDW-1:0]    prio_idx = addr[IDW+1:2];

  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      thr_hit[c]   = addr == ADDR_W'(CX_BASE + c * CX_STEP);
      claim_hit[c] = rd_en && addr == ADDR_W'(CX_BASE + c * CX_STEP + 4);
      cmpl_hit[c]  = wr_en && addr == ADDR_W'(CX_BASE + c * CX_STEP + 4);
    end
  end

  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      best_id[c] = '0;
      best_pr[c] = '0;
      for (int i = 1; i < NSRC; i++)
        if (pend[i] && en[c][i] && prio[i] > thr[c] && prio[i] > best_pr[c]) begin
          best_id[c] = IDW'(i);
          best_pr[c] = prio[i];
        end
    end
  end

  always_comb begin
    clm = '0;
    cmp = '0;
    for (int c = 0; c < NCTX; c++)
      for (int i = 1; i < NSRC; i++) begin
        if (claim_hit[c] && best_id[c] == IDW'(i)) clm[i] = 1'b1;
        if (cmpl_hit[c] && wr_data == 32'(i) && en[c][i]) cmp[i] = 1'b1;
      end
  end

  always_comb begin
    rd_val = '0;
    if (is_prio) rd_val = 32'(prio[prio_idx]);
    for (int c = 0; c < NCTX; c++) begin
      for (int w = 0; w < NWORDS; w++)
        if (addr == ADDR_W'(EN_BASE + c * EN_STEP + 4 * w))
          for (int b = 0; b < 32; b++)
            if (32 * w + b < NSRC) rd_val[b] = en[c][32 * w + b];
      if (thr_hit[c]) rd_val = 32'(thr[c]);
      if (claim_hit[c]) rd_val = 32'(best_id[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      irq_o   <= '0;
      pend    <= '0;
      busy    <= '0;
      for (int i = 0; i < NSRC; i++) prio[i] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
    end else begin
      if (rd_en) rd_data <= rd_val;
      for (int c = 0; c < NCTX; c++) irq_o[c] <= best_id[c] != '0;
      for (int i = 1; i < NSRC; i++) begin
        pend[i] <= clm[i] ? 1'b0 : (pend[i] | (src_irq[i] & ~busy[i]));
        busy[i] <= clm[i] ? 1'b1 : (cmp[i] ? 1'b0 : busy[i]);
      end
      if (wr_en) begin
        if (is_prio && prio_idx != '0) prio[prio_idx] <= wr_data[PRIO_W-1:0];
        for (int c = 0; c < NCTX; c++) begin
          if (thr_hit[c]) thr[c] <= wr_data[PRIO_W-1:0];
          for (int w = 0; w < NWORDS; w++)
            if (addr == ADDR_W'(EN_BASE + c * EN_STEP + 4 * w))
              for (int b = 0; b < 32; b++)
                if (32 * w + b < NSRC && 32 * w + b != 0) en[c][32 * w + b] <= wr_data[b];
        end
      end
    end
  end

  AST_PEND_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & busy) == '0); // R6

  AST_ID0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == '0) |=> rd_data == '0); // R1

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx_chk
    AST_MAX_THR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(thr[c]) == '1) |-> !irq_o[c]); // R3

    AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_hit[c] && best_id[c] != '0) |=>
        busy[$past(best_id[c])] && !pend[$past(best_id[c])]); // R6
  end
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en;
  logic [31:0] src_irq;
  logic [21:0] addr;
  logic [31:0] wr_data, rd_data, v;
  logic [1:0]  irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_router uut (.clk(clk), .rst_n(rst_n), .src_irq(src_irq), .wr_en(wr_en),
                  .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
                  .rd_data(rd_data), .irq_o(irq_o));

  function automatic logic [21:0] PRI(int n); return 22'(4 * n); endfunction
  function automatic logic [21:0] ENA(int c); return 22'('h2000 + 'h80 * c); endfunction
  function automatic logic [21:0] THR(int c); return 22'('h200000 + 'h1000 * c); endfunction
  function automatic logic [21:0] CLM(int c); return 22'('h200000 + 'h1000 * c + 4); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [21:0] a, logic [31:0] d);
    @(negedge clk) addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic rd(logic [21:0] a, output logic [31:0] d);
    @(negedge clk) addr = a; rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0; d = rd_data;
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic do_reset;
    @(negedge clk) rst_n = 1'b0; src_irq = '0;
    idle(2);
    rst_n = 1'b1;
  endtask

  // {prio3, prio5, prio9, thr0, expected claim id}
  localparam logic [16:0] VEC [8] = '{
    {3'd1, 3'd2, 3'd3, 3'd0, 5'd9},
    {3'd3, 3'd3, 3'd1, 3'd0, 5'd3},
    {3'd2, 3'd7, 3'd7, 3'd0, 5'd5},
    {3'd4, 3'd4, 3'd4, 3'd4, 5'd0},
    {3'd5, 3'd4, 3'd4, 3'd4, 5'd3},
    {3'd0, 3'd0, 3'd1, 3'd0, 5'd9},
    {3'd7, 3'd7, 3'd7, 3'd7, 5'd0},
    {3'd0, 3'd0, 3'd0, 3'd0, 5'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0; src_irq = '0;
    idle(3);
    rst_n = 1'b1;

    // R5 R3 vector walk
    wr(ENA(0), 32'h228);
    src_irq = 32'h228;
    for (int k = 0; k < 8; k++) begin
      wr(PRI(3), 32'(VEC[k][16:14]));
      wr(PRI(5), 32'(VEC[k][13:11]));
      wr(PRI(9), 32'(VEC[k][10:8]));
      wr(THR(0), 32'(VEC[k][7:5]));
      idle(2);
      chk("R3 irq level", 32'(irq_o[0]), 32'(VEC[k][4:0] != 0));
      rd(CLM(0), v);
      chk("R5 claim winner", v, 32'(VEC[k][4:0]));
      if (VEC[k][4:0] != 0) wr(CLM(0), 32'(VEC[k][4:0]));
    end

    // R1 reset state and source 0
    do_reset();
    idle(1);
    chk("R9 irq after reset", 32'(irq_o), 32'h0);
    rd(CLM(0), v); chk("R1 empty claim", v, 32'h0);
    wr(PRI(0), 32'h7);
    rd(PRI(0), v); chk("R1 prio id0", v, 32'h0);

    // R2 register map
    wr(PRI(4), 32'hFF);
    rd(PRI(4), v); chk("R2 prio masked", v, 32'h7);
    wr(THR(1), 32'h3);
    rd(THR(1), v); chk("R2 threshold", v, 32'h3);
    wr(ENA(1), 32'h11);
    rd(ENA(1), v); chk("R2 enable bit0 fixed", v, 32'h10);

    // R4 per-context enables
    src_irq[4] = 1'b1;
    idle(3);
    chk("R4 irq routing", 32'(irq_o), 32'h2);
    rd(CLM(0), v); chk("R4 other context", v, 32'h0);
    rd(CLM(1), v); chk("R5 claim ctx1", v, 32'h4);

    // R6 in service blocks held input
    idle(3);
    chk("R6 irq dropped", 32'(irq_o[1]), 32'h0);
    rd(CLM(1), v); chk("R6 no reclaim", v, 32'h0);

    // R8 ignored completions
    wr(CLM(1), 32'd36);
    idle(3);
    rd(CLM(1), v); chk("R8 out of range", v, 32'h0);
    wr(ENA(1), 32'h0);
    wr(CLM(1), 32'd4);
    wr(ENA(1), 32'h10);
    idle(3);
    rd(CLM(1), v); chk("R8 disabled complete", v, 32'h0);
    wr(CLM(0), 32'd4);
    idle(3);
    rd(CLM(1), v); chk("R8 wrong context", v, 32'h0);

    // R8 valid completion
    wr(CLM(1), 32'd4);
    idle(3);
    chk("R8 repend irq", 32'(irq_o[1]), 32'h1);
    rd(CLM(1), v); chk("R8 reclaim", v, 32'h4);
    src_irq[4] = 1'b0;
    wr(CLM(1), 32'd4);

    // R7 drain in order
    wr(PRI(3), 32'd2); wr(PRI(5), 32'd6); wr(PRI(9), 32'd6);
    wr(ENA(0), 32'h228); wr(THR(0), 32'd1);
    @(negedge clk) src_irq = 32'h228;
    @(negedge clk) src_irq = '0;
    idle(2);
    rd(CLM(0), v); chk("R7 first", v, 32'd5);
    rd(CLM(0), v); chk("R7 second", v, 32'd9);
    rd(CLM(0), v); chk("R7 third", v, 32'd3);
    rd(CLM(0), v); chk("R7 empty", v, 32'd0);
    wr(CLM(0), 32'd3); wr(CLM(0), 32'd5); wr(CLM(0), 32'd9);

    // R3 thresholds and R9 timing
    wr(THR(0), 32'd7);
    @(negedge clk) src_irq[3] = 1'b1;
    @(negedge clk) src_irq[3] = 1'b0;
    idle(2);
    chk("R3 max threshold", 32'(irq_o[0]), 32'h0);
    wr(THR(0), 32'd2);
    idle(2);
    chk("R3 equal not enough", 32'(irq_o[0]), 32'h0);
    @(negedge clk) addr = THR(0); wr_data = 32'd1; wr_en = 1'b1;
    @(negedge clk) wr_en = 1'b0;
    chk("R9 not yet", 32'(irq_o[0]), 32'h0);
    @(negedge clk);
    chk("R9 one cycle later", 32'(irq_o[0]), 32'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule